// File: doc/BRIEF.md
# Handshaked Two-Tap Averaging Filter

This block is a streaming filter that accepts unsigned samples over a four-phase request/acknowledge input channel. It emits the mean of each new sample and the sample that came before it over a four-phase output channel. The history value starts at zero, so the first result is half of the first sample. The division by two truncates. The sum is formed one bit wider than the data, so no carry is lost.

Inside, a clocked controller steps through a fixed chain of handshakes:

1. Capture the input sample into a holding register.
2. Start an adder whose done signal follows its start after a parameterised matched delay.
3. Capture the halved sum into the output register and offer it to the consumer.
4. Once the consumer acknowledges, copy the held sample into the history register.
5. Acknowledge the producer.

Every request then returns to zero before the filter takes the next sample. Because the history is written only after the output has been accepted, the result always uses the old history value. The producer may change its data as soon as the input acknowledge rises.

Top module: `pair_mean_filter`

## Requirements
- R1: While reset is held and right after it, `in_ack` and `out_req` are low, and the history value is zero, so the first result is the first sample shifted right by one.
- R2: Each result equals (x + y) >> 1. The sum is computed on DW+1 bits, so two all-ones samples give all ones.
- R3: After each transaction the history y equals that transaction's input x, so result n uses sample n-1 (or zero for n = 0).
- R4: `in_ack` rises for a sample only after the consumer has raised `out_ack` for that sample's result.
- R5: `out_data` stays stable for as long as `out_req` is high.
- R6: `in_ack` falls only after `in_req` is low and `out_ack` is low. `out_req` has already fallen before `in_ack` falls.
- R7: `out_req` rises only while `in_req` is high and `in_ack` is low.
- R8: Changes on `in_data` after `in_ack` has risen have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | 1 | Producer request; high means in_data is valid |
| in_ack | output | 1 | Acknowledge to producer |
| in_data | input | DW | Input sample, unsigned |
| out_req | output | 1 | Result valid request to consumer |
| out_ack | input | 1 | Consumer acknowledge |
| out_data | output | DW | Mean of current and previous sample |

## Verification
The bench aims at the following corner cases and the failures each one would expose:

- **First sample after reset.** A filter that does not clear the history would give a wrong first result.
- **Two all-ones samples.** An adder that drops the carry bit returns a halved value near half scale.
- **Odd sums.** A design that rounds instead of truncating is off by one.
- **Garbage on `in_data` after `in_ack`.** A design that samples late, or that writes the history from the live input, leaks this garbage into later results.
- **Slow consumer with random delays.** A controller that writes the history before the output is accepted produces means of the wrong pair. One that acknowledges the producer early breaks the ordering checks.

// File: rtl/pmf_pkg.sv
package pmf_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LDX   = 3'd1,
      ST_ADD   = 3'd2,
      ST_OUT   = 3'd3,
      ST_LDY   = 3'd4,
      ST_ACKIN = 3'd5,
      ST_RTZ   = 3'd6
   } pmf_state_t;
endpackage

// File: rtl/pmf_hs_reg.sv
module pmf_hs_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req,
   input  logic [W-1:0] d,
   output logic         ack,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack <= 1'b0;
         q   <= '0;
      end else if (req && !ack) begin
         q   <= d;
         ack <= 1'b1;
      end else if (!req) begin
         ack <= 1'b0;
      end
   end

   // R3
   reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && $past(ack)) |-> $stable(q));
endmodule

// File: rtl/pmf_adder.sv
module pmf_adder #(
   parameter int W     = 8,
   parameter int DELAY = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         done,
   output logic [W:0]   sum
);
   localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);

   always_ff @(posedge clk) begin
      if (!rst_n)                sum <= '0;
      else if (start && !done)   sum <= {1'b0, a} + {1'b0, b};
   end

   generate
      if (DELAY <= 1) begin : g_fast
         always_ff @(posedge clk) begin
            if (!rst_n) done <= 1'b0;
            else        done <= start;
         end
      end else begin : g_matched
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || !start) begin
               cnt  <= '0;
               done <= 1'b0;
            end else if (!done) begin
               if (cnt == CW'(DELAY - 1)) done <= 1'b1;
               else                       cnt  <= cnt + 1'b1;
            end
         end
      end
   endgenerate

   // R2
   sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(done)) |-> $stable(sum));
endmodule

// File: rtl/pmf_ctrl.sv
module pmf_ctrl
   import pmf_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic in_req,
   input  logic out_ack,
   input  logic ax,
   input  logic aa,
   input  logic ao,
   input  logic ay,
   output logic rx,
   output logic ra,
   output logic ro,
   output logic ry,
   output logic in_ack
);
   pmf_state_t st, st_nx;

   always_ff @(posedge clk) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nx;
   end

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE:  if (in_req)                          st_nx = ST_LDX;
         ST_LDX:   if (ax)                              st_nx = ST_ADD;
         ST_ADD:   if (aa)                              st_nx = ST_OUT;
         ST_OUT:   if (ao && out_ack)                   st_nx = ST_LDY;
         ST_LDY:   if (ay)                              st_nx = ST_ACKIN;
         ST_ACKIN: if (!in_req)                         st_nx = ST_RTZ;
         ST_RTZ:   if (!(ax || aa || ao || ay || out_ack)) st_nx = ST_IDLE;
         default:                                       st_nx = ST_IDLE;
      endcase
   end

   assign rx     = (st == ST_LDX) || (st == ST_ADD) || (st == ST_OUT) ||
                   (st == ST_LDY) || (st == ST_ACKIN);
   assign ra     = (st == ST_ADD) || (st == ST_OUT) || (st == ST_LDY) ||
                   (st == ST_ACKIN);
   assign ro     = (st == ST_OUT) || (st == ST_LDY) || (st == ST_ACKIN);
   assign ry     = (st == ST_LDY) || (st == ST_ACKIN);
   assign in_ack = (st == ST_ACKIN) || (st == ST_RTZ);
endmodule

// File: rtl/pair_mean_filter.sv
module pair_mean_filter #(
   parameter int DW        = 8,
   parameter int ADD_DELAY = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_req,
   output logic          in_ack,
   input  logic [DW-1:0] in_data,
   output logic          out_req,
   input  logic          out_ack,
   output logic [DW-1:0] out_data
);
   localparam int SW = DW + 1;

   generate
      if (DW < 1) begin : g_bad_dw
         $error("pair_mean_filter: DW must be at least 1");
      end
      if (ADD_DELAY < 0) begin : g_bad_delay
         $error("pair_mean_filter: ADD_DELAY must not be negative");
      end
   endgenerate

   logic          rx, ra, ro, ry;
   logic          ax, aa, ao, ay;
   logic [DW-1:0] x_q, y_q;
   logic [SW-1:0] sum;
   logic [DW-1:0] mean;

   pmf_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .in_req(in_req), .out_ack(out_ack),
      .ax(ax), .aa(aa), .ao(ao), .ay(ay),
      .rx(rx), .ra(ra), .ro(ro), .ry(ry), .in_ack(in_ack)
   );

   pmf_hs_reg #(.W(DW)) u_xreg (
      .clk(clk), .rst_n(rst_n), .req(rx), .d(in_data), .ack(ax), .q(x_q)
   );

   pmf_adder #(.W(DW), .DELAY(ADD_DELAY)) u_add (
      .clk(clk), .rst_n(rst_n), .start(ra), .a(x_q), .b(y_q),
      .done(aa), .sum(sum)
   );

   assign mean = sum[SW-1:1];

   pmf_hs_reg #(.W(DW)) u_oreg (
      .clk(clk), .rst_n(rst_n), .req(ro), .d(mean), .ack(ao), .q(out_data)
   );

   pmf_hs_reg #(.W(DW)) u_yreg (
      .clk(clk), .rst_n(rst_n), .req(ry), .d(x_q), .ack(ay), .q(y_q)
   );

   assign out_req = ro && ao;

   // R7
   out_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_req) |-> (in_req && !in_ack));
   // R5
   out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_req && $past(out_req)) |-> $stable(out_data));
   // R4
   ack_after_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ack) |-> (out_ack && ay));
   // R6
   ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_ack) |-> (!in_req && !out_ack && !out_req));
   // R3
   hist_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ay) |-> $past(out_ack));
endmodule

// File: tb/test_pair_mean_filter.sv
`timescale 1ns/1ps
module test_pair_mean_filter;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_req = 1'b0;
   logic          out_ack = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          in_ack, out_req;
   logic [DW-1:0] out_data;

   int checks = 0;
   int errors = 0;
   int produced = 0;
   int accepted = 0;
   logic [DW-1:0] exp_q [0:1023];
   logic [DW-1:0] y_model = '0;

   always #2.5 clk = ~clk;

   pair_mean_filter #(.DW(DW), .ADD_DELAY(3)) i_pair_mean_filter (
      .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_ack(in_ack),
      .in_data(in_data), .out_req(out_req), .out_ack(out_ack),
      .out_data(out_data)
   );

   function automatic logic [DW-1:0] ref_mean(logic [DW-1:0] x, logic [DW-1:0] y);
      logic [DW:0] s;
      s = {1'b0, x} + {1'b0, y};
      return s[DW:1];
   endfunction

   task automatic check(string tag, longint act, longint expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   task automatic send(logic [DW-1:0] x, int hold);
      @(negedge clk);
      in_data = x;
      in_req  = 1'b1;
      exp_q[produced % 1024] = ref_mean(x, y_model);
      y_model = x;
      produced++;
      while (!in_ack) @(negedge clk);
      // R4: acknowledge only after the result was taken
      check("R4 in_ack after out_ack", accepted, produced);
      in_data = DW'($urandom);   // R8: garbage after in_ack
      repeat (hold) @(negedge clk);
      in_req = 1'b0;
      while (in_ack) @(negedge clk);
      // R6: output request already released
      check("R6 out_req low at in_ack fall", out_req, 0);
   endtask

   initial begin : consumer
      forever begin
         @(negedge clk);
         if (out_req) begin
            int d;
            logic [DW-1:0] snap;
            // R7
            check("R7 out_req start cond", {in_req, in_ack}, 2'b10);
            check("R2 R3 R8 result", out_data, exp_q[accepted % 1024]);
            snap = out_data;
            d = $urandom_range(0, 4);
            repeat (d) begin
               @(negedge clk);
               // R5
               check("R5 out_data stable", out_data, snap);
            end
            out_ack = 1'b1;
            accepted++;
            while (out_req) @(negedge clk);
            repeat ($urandom_range(0, 3)) @(negedge clk);
            out_ack = 1'b0;
         end
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 in_ack in reset", in_ack, 0);
      check("R1 out_req in reset", out_req, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 out_req after reset", out_req, 0);
      // R1: first result uses zero history (201 >> 1 = 100)
      send(8'd201, 0);
      // R2: carry kept, 255+255 -> 255 after 201 gives 228
      send(8'd255, 1);
      send(8'd255, 2);
      // R2: truncation 255+0 -> 127, 0+1 -> 0
      send(8'd0, 0);
      send(8'd1, 3);
      send(8'd2, 0);
      for (int i = 0; i < 200; i++) begin
         send(DW'($urandom), $urandom_range(0, 5));
         repeat ($urandom_range(0, 3)) @(negedge clk);
      end
      begin
         int t = 0;
         while (accepted != produced && t < 100) begin
            @(negedge clk);
            t++;
         end
      end
      // R3: every sample paired with its predecessor
      check("R3 all results seen", accepted, produced);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule